// File: doc/BRIEF.md
# MDIO Management Master

This block lets a host read and write the management registers of Ethernet PHYs over the two-wire MDC/MDIO bus. The host reaches it through a small word-addressed register window. It loads a target (register number, PHY address and a read/write flag) and, for writes, a 16-bit data word. It then writes the control word with the go bit set. The block serialises one clause-22 management frame, leaves the go bit reading 1 while the frame is on the wire, and clears it at the end. After a read frame, the word returned by the PHY appears in the read-data register.

MDC is produced only while a frame is in flight and is the system clock divided by an even parameter `DIV`. The MDIO pad is split into an output, an output enable and an input, so a tri-state buffer and a pull-up go outside the block. All three bus pins are plain control pins. There is no streaming data path, so none of them carries a valid/ready handshake. The host access is a single-cycle write strobe with a combinational read.

Top module: `mdio_master`

## Requirements
- R1: After reset, every register reads 0, MDC is low and the MDIO output enable is low.
- R2: The target register (byte offset 0x7E4) keeps bits 10:0 and reads the rest as 0. Bits 4:0 are the PHY register number, bits 9:5 the PHY address, and bit 10 the direction (1 = read, 0 = write). The write-data register (offset 0x7E8) keeps bits 15:0.
- R3: In the control register (offset 0x7F0), bit 3 is the interface enable and reads back as last written.
- R4: A control write with bit 0 (go) and bit 3 both set, made while idle, makes bit 0 read 1 from the next cycle on. Bit 0 stays 1 for exactly 64*DIV+1 cycles and then reads 0.
- R5: A go request written with bit 3 clear starts nothing: no MDC edge appears and bit 0 reads 0.
- R6: A go request written while a frame is in progress is ignored. The running frame is unchanged, and no second frame follows it.
- R7: Each frame is 64 bits, sent MSB first: 32 ones, start 01, opcode 10 for read or 01 for write, 5-bit PHY address, 5-bit register number, turnaround 10 on writes, then the 16 write-data bits.
- R8: The output enable is high from the first frame bit. On a read it drops for the last 18 bits (turnaround and data); on a write it stays high for all 64 bits.
- R9: A read captures 16 bits from the MDIO input at the rising MDC edges of the data phase, MSB first, into the read-data register (offset 0x7EC). An input held high yields 0xFFFF. A write frame leaves this register unchanged.
- R10: While a frame runs, MDC has a period of DIV clock cycles, high and low for DIV/2 each. It stays low while idle.
- R11: The MDIO output changes only in cycles where MDC has just fallen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr | input | 1 | Register write strobe |
| host_addr | input | ADDR_W | Byte address of the register accessed |
| host_wdata | input | 32 | Register write data |
| host_rdata | output | 32 | Combinational read data for host_addr |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable (1 = drive) |
| mdio_i | input | 1 | MDIO input, pulled high outside |

## Verification
The bench builds the block with DIV = 4, so MDC runs at a quarter of the system clock and a full frame takes 256 cycles. At that length, several read and write frames, a frame hit by a second go request and a frame with an absent PHY all fit in a short run. The small divisor still keeps separate high and low phases of two cycles each, so the sampling on the rising edge and the updates on the falling edge land on distinct cycles. The default divisor of 40 uses the same counter path with a wider count.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int FRAME_LEN   = 64;
  localparam int IDX_W       = $clog2(FRAME_LEN);
  localparam int PRE_LEN     = 32;
  localparam int DATA_LEN    = 16;
  localparam int RELEASE_IDX = 46;
  localparam int DATA_IDX    = FRAME_LEN - DATA_LEN;
  localparam int HOST_W      = 32;

  localparam logic [11:0] OFS_TARGET = 12'h7E4;
  localparam logic [11:0] OFS_WDATA  = 12'h7E8;
  localparam logic [11:0] OFS_RDATA  = 12'h7EC;
  localparam logic [11:0] OFS_CTRL   = 12'h7F0;

  localparam int GO_BIT = 0;
  localparam int EN_BIT = 3;

  localparam logic [1:0] SOF     = 2'b01;
  localparam logic [1:0] OP_RD   = 2'b10;
  localparam logic [1:0] OP_WR   = 2'b01;
  localparam logic [1:0] TA_WR   = 2'b10;
  localparam logic [1:0] TA_IDLE = 2'b11;

  typedef struct packed {
    logic       is_rd;
    logic [4:0] phy;
    logic [4:0] regn;
  } mdio_target_t;

  function automatic logic [FRAME_LEN-1:0] build_frame(
    input mdio_target_t t, input logic [DATA_LEN-1:0] d);
    return {{PRE_LEN{1'b1}}, SOF, (t.is_rd ? OP_RD : OP_WR), t.phy, t.regn,
            (t.is_rd ? TA_IDLE : TA_WR), (t.is_rd ? {DATA_LEN{1'b0}} : d)};
  endfunction
endpackage

// File: rtl/mdio_clkdiv.sv
module mdio_clkdiv #(
  parameter int DIV = 40
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic mdc,
  output logic rise_tick,
  output logic fall_tick
);
  localparam int HALF = DIV / 2;
  localparam int CW   = (HALF > 1) ? $clog2(HALF) : 1;

  logic [CW-1:0] cnt;
  logic          at_end;

  assign at_end    = (cnt == CW'(HALF - 1));
  assign rise_tick = run & at_end & ~mdc;
  assign fall_tick = run & at_end & mdc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (!run) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (at_end) begin
      cnt <= '0;
      mdc <= ~mdc;
    end else begin
      cnt <= cnt + CW'(1);
    end
  end
endmodule

// File: rtl/mdio_frame_shifter.sv
module mdio_frame_shifter
  import mdio_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  mdio_target_t        target,
  input  logic [DATA_LEN-1:0] wr_data,
  input  logic                rise_tick,
  input  logic                fall_tick,
  input  logic                mdi,
  output logic                busy,
  output logic                mdo,
  output logic                oe,
  output logic                done,
  output logic                rd_valid,
  output logic [DATA_LEN-1:0] rd_data
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_LEN - 1);

  logic [FRAME_LEN-1:0] sh;
  logic [IDX_W-1:0]     idx;
  logic                 is_rd;
  logic [DATA_LEN-1:0]  rd_sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh    <= '0;
      idx   <= '0;
      busy  <= 1'b0;
      is_rd <= 1'b0;
      rd_sh <= '0;
    end else if (start && !busy) begin
      sh    <= build_frame(target, wr_data);
      idx   <= '0;
      busy  <= 1'b1;
      is_rd <= target.is_rd;
      rd_sh <= '0;
    end else if (busy) begin
      if (rise_tick && is_rd && idx >= IDX_W'(DATA_IDX))
        rd_sh <= {rd_sh[DATA_LEN-2:0], mdi};
      if (fall_tick) begin
        if (idx == LAST_IDX) begin
          busy <= 1'b0;
        end else begin
          idx <= idx + IDX_W'(1);
          sh  <= {sh[FRAME_LEN-2:0], 1'b0};
        end
      end
    end
  end

  assign mdo      = sh[FRAME_LEN-1];
  assign oe       = busy & ~(is_rd & (idx >= IDX_W'(RELEASE_IDX)));
  assign done     = busy & fall_tick & (idx == LAST_IDX);
  assign rd_valid = done & is_rd;
  assign rd_data  = rd_sh;
endmodule

// File: rtl/mdio_regs.sv
module mdio_regs
  import mdio_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                host_wr,
  input  logic [ADDR_W-1:0]   host_addr,
  input  logic [HOST_W-1:0]   host_wdata,
  output logic [HOST_W-1:0]   host_rdata,
  input  logic                busy,
  input  logic                rd_valid,
  input  logic [DATA_LEN-1:0] rd_data,
  output mdio_target_t        target,
  output logic [DATA_LEN-1:0] wr_data,
  output logic                en,
  output logic                start
);
  logic [DATA_LEN-1:0] rd_q;
  logic                busy_any;
  logic                hit_tgt, hit_wd, hit_ctrl;

  assign busy_any = busy | start;
  assign hit_tgt  = host_wr && (host_addr == ADDR_W'(OFS_TARGET));
  assign hit_wd   = host_wr && (host_addr == ADDR_W'(OFS_WDATA));
  assign hit_ctrl = host_wr && (host_addr == ADDR_W'(OFS_CTRL));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      target  <= '0;
      wr_data <= '0;
      rd_q    <= '0;
      en      <= 1'b0;
      start   <= 1'b0;
    end else begin
      if (hit_tgt)  target  <= host_wdata[$bits(mdio_target_t)-1:0];
      if (hit_wd)   wr_data <= host_wdata[DATA_LEN-1:0];
      if (hit_ctrl) en      <= host_wdata[EN_BIT];
      if (rd_valid) rd_q    <= rd_data;
      start <= hit_ctrl & host_wdata[GO_BIT] & host_wdata[EN_BIT] & ~busy_any;
    end
  end

  always_comb begin
    host_rdata = '0;
    if (host_addr == ADDR_W'(OFS_TARGET))
      host_rdata[$bits(mdio_target_t)-1:0] = target;
    else if (host_addr == ADDR_W'(OFS_WDATA))
      host_rdata[DATA_LEN-1:0] = wr_data;
    else if (host_addr == ADDR_W'(OFS_RDATA))
      host_rdata[DATA_LEN-1:0] = rd_q;
    else if (host_addr == ADDR_W'(OFS_CTRL)) begin
      host_rdata[GO_BIT] = busy_any;
      host_rdata[EN_BIT] = en;
    end
  end
endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_pkg::*;
#(
  parameter int DIV    = 40,
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_wr,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [31:0]       host_wdata,
  output logic [31:0]       host_rdata,
  output logic              mdc,
  output logic              mdio_o,
  output logic              mdio_oe,
  input  logic              mdio_i
);
  mdio_target_t        target;
  logic [DATA_LEN-1:0] wr_data, rd_data;
  logic                mdio_en, start_pulse, frame_busy, frame_done, rd_valid;
  logic                rise_tick, fall_tick;

  mdio_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .busy(frame_busy),
    .rd_valid(rd_valid), .rd_data(rd_data), .target(target),
    .wr_data(wr_data), .en(mdio_en), .start(start_pulse)
  );

  mdio_clkdiv #(.DIV(DIV)) u_div (
    .clk(clk), .rst_n(rst_n), .run(frame_busy), .mdc(mdc),
    .rise_tick(rise_tick), .fall_tick(fall_tick)
  );

  mdio_frame_shifter u_shift (
    .clk(clk), .rst_n(rst_n), .start(start_pulse), .target(target),
    .wr_data(wr_data), .rise_tick(rise_tick), .fall_tick(fall_tick),
    .mdi(mdio_i), .busy(frame_busy), .mdo(mdio_o), .oe(mdio_oe),
    .done(frame_done), .rd_valid(rd_valid), .rd_data(rd_data)
  );
endmodule

// File: rtl/mdio_master_chk.sv
module mdio_master_chk #(
  parameter int DIV = 40
) (
  input logic clk,
  input logic rst_n,
  input logic mdc,
  input logic mdio_o,
  input logic mdio_oe,
  input logic busy,
  input logic done,
  input logic start,
  input logic en
);
  localparam int HALF = DIV / 2;

  logic        mdc_q;
  logic [15:0] hc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mdc_q <= 1'b0;
      hc    <= '0;
    end else begin
      mdc_q <= mdc;
      if (!busy || (mdc != mdc_q)) hc <= '0;
      else                         hc <= hc + 16'd1;
    end
  end

  // R10
  mdc_idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mdc);

  // R10
  mdc_half_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !mdc && mdc_q) |-> (hc == 16'(HALF - 1)));

  // R11
  mdo_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && (mdio_o != $past(mdio_o))) |-> (!mdc && $past(mdc)));

  // R4
  go_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> busy);

  // R5
  start_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> en);

  // R6
  start_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !busy);

  // R8
  drive_from_first_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> mdio_oe);
endmodule

bind mdio_master mdio_master_chk #(.DIV(DIV)) u_chk (
  .clk(clk), .rst_n(rst_n), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
  .busy(frame_busy), .done(frame_done), .start(start_pulse), .en(mdio_en)
);

// File: tb/tb_mdio_master.sv
module tb_mdio_master;
  localparam int PERIOD = 10;
  localparam int DIV    = 4;
  localparam int NVEC   = 5;
  localparam logic [11:0] A_TGT = 12'h7E4, A_WD = 12'h7E8, A_RD = 12'h7EC, A_CTL = 12'h7F0;
  // fields: [43] read, [42:38] phy, [37:33] reg, [32:17] wdata, [16:1] phy reply, [0] phy present
  localparam logic [43:0] VEC [NVEC] = '{
    {1'b0, 5'd1,  5'd0,  16'hA5C3, 16'h0000, 1'b1},
    {1'b1, 5'd31, 5'd1,  16'h0000, 16'h7949, 1'b1},
    {1'b1, 5'd0,  5'd31, 16'h0000, 16'h8001, 1'b1},
    {1'b0, 5'd21, 5'd10, 16'hFFFF, 16'h0000, 1'b1},
    {1'b1, 5'd9,  5'd2,  16'h1234, 16'h0F0F, 1'b0}
  };

  logic clk = 1'b0, rst_n = 1'b0, host_wr = 1'b0, mdio_i = 1'b1;
  logic [11:0] host_addr = '0;
  logic [31:0] host_wdata = '0, host_rdata;
  logic mdc, mdio_o, mdio_oe;

  int total = 0, bad = 0, phy_cnt = 0;
  logic [63:0] cap_bit, cap_oe;
  logic [15:0] resp = '0;
  logic present = 1'b1;

  always #(PERIOD/2) clk = ~clk;

  mdio_master #(.DIV(DIV), .ADDR_W(12)) dut (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .mdc(mdc),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  initial forever begin
    @(posedge mdc);
    phy_cnt = phy_cnt + 1;
    if (phy_cnt >= 1 && phy_cnt <= 64) begin
      cap_bit[64-phy_cnt] = mdio_o;
      cap_oe[64-phy_cnt]  = mdio_oe;
    end
  end

  initial forever begin
    @(negedge mdc);
    if (!present) mdio_i = 1'b1;
    else if (phy_cnt >= 48 && phy_cnt <= 63) mdio_i = resp[63-phy_cnt];
    else if (phy_cnt == 47) mdio_i = 1'b0;
    else mdio_i = 1'b1;
  end

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic host_write(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    host_wr = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic host_read(input logic [11:0] a, output logic [31:0] d);
    host_addr = a;
    #1 d = host_rdata;
  endtask

  task automatic wait_idle(output int n);
    logic [31:0] s;
    n = 0;
    host_read(A_CTL, s);
    while (s[0] && n < 5000) begin
      n++;
      @(negedge clk);
      host_read(A_CTL, s);
    end
  endtask

  task automatic arm;
    phy_cnt = 0; cap_bit = '0; cap_oe = '0;
  endtask

  initial begin
    #(PERIOD * 150000);
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] r;
    logic [15:0] last_rd;
    logic [63:0] exp;
    int n;
    time t0, t1, t2;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    host_read(A_TGT, r); check(r == 0, "R1 target", r, 0);
    host_read(A_WD, r);  check(r == 0, "R1 wdata", r, 0);
    host_read(A_RD, r);  check(r == 0, "R1 rdata", r, 0);
    host_read(A_CTL, r); check(r == 0, "R1 ctrl", r, 0);
    check(!mdc && !mdio_oe, "R1 pins", {mdc, mdio_oe}, 0);

    // R2 field widths
    host_write(A_TGT, 32'hFFFF_FFFF); host_read(A_TGT, r);
    check(r == 32'h7FF, "R2 target", r, 32'h7FF);
    host_write(A_WD, 32'hFFFF_FFFF); host_read(A_WD, r);
    check(r == 32'hFFFF, "R2 wdata", r, 32'hFFFF);
    // R3 enable readback
    host_write(A_CTL, 32'h8); host_read(A_CTL, r);
    check(r == 32'h8, "R3 set", r, 32'h8);
    host_write(A_CTL, 32'h0); host_read(A_CTL, r);
    check(r == 32'h0, "R3 clear", r, 32'h0);

    last_rd = 16'h0;
    for (int i = 0; i < NVEC; i++) begin
      logic [43:0] v;
      logic [15:0] exp_rd;
      v = VEC[i];
      resp = v[16:1]; present = v[0];
      host_write(A_TGT, {21'b0, v[43], v[42:38], v[37:33]});
      host_write(A_WD, {16'b0, v[32:17]});
      arm();
      host_write(A_CTL, 32'h9);
      wait_idle(n);
      check(n == 64*DIV + 1, "R4 busy length", n, 64*DIV + 1);
      exp = {32'hFFFF_FFFF, 2'b01, (v[43] ? 2'b10 : 2'b01), v[42:38], v[37:33], 2'b10, v[32:17]};
      if (v[43]) begin
        check(cap_bit[63:18] == exp[63:18], "R7 read frame", cap_bit, exp);
        check(cap_oe == {{46{1'b1}}, 18'b0}, "R8 read release", cap_oe, {{46{1'b1}}, 18'b0});
        exp_rd = present ? resp : 16'hFFFF;
      end else begin
        check(cap_bit == exp, "R7 write frame", cap_bit, exp);
        check(cap_oe == '1, "R8 write drive", cap_oe, '1);
        exp_rd = last_rd;
      end
      host_read(A_RD, r);
      check(r == {16'b0, exp_rd}, "R9 read data", r, {16'b0, exp_rd});
      last_rd = exp_rd;
    end

    // R6 go while busy ignored
    present = 1'b1; resp = 16'h5555;
    host_write(A_TGT, {21'b0, 1'b1, 5'd3, 5'd4});
    arm();
    host_write(A_CTL, 32'h9);
    repeat (40) @(negedge clk);
    host_write(A_TGT, {21'b0, 1'b0, 5'd17, 5'd18});
    host_write(A_CTL, 32'h9);
    wait_idle(n);
    exp = {32'hFFFF_FFFF, 2'b01, 2'b10, 5'd3, 5'd4, 18'b0};
    check(cap_bit[63:18] == exp[63:18], "R6 frame kept", cap_bit, exp);
    repeat (100) @(negedge clk);
    check(phy_cnt == 64, "R6 no second frame", phy_cnt, 64);
    host_read(A_RD, r);
    check(r == 32'h5555, "R6 read result", r, 32'h5555);

    // R5 go without enable
    arm();
    host_write(A_CTL, 32'h1);
    host_read(A_CTL, r);
    check(r == 0, "R5 status", r, 0);
    repeat (50) @(negedge clk);
    check(phy_cnt == 0 && !mdc, "R5 no mdc", phy_cnt, 0);

    // R10 MDC period and duty
    arm();
    host_write(A_CTL, 32'h9);
    @(posedge mdc); t0 = $time;
    @(negedge mdc); t1 = $time;
    @(posedge mdc); t2 = $time;
    check(t2 - t0 == DIV*PERIOD, "R10 period", t2 - t0, DIV*PERIOD);
    check(t1 - t0 == (DIV/2)*PERIOD, "R10 high time", t1 - t0, (DIV/2)*PERIOD);
    @(negedge clk);
    wait_idle(n);
    repeat (3) @(negedge clk);
    check(!mdc, "R10 idle low", mdc, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule